// File: doc/BRIEF.md
# Cascadable Bidirectional Column-Group Sampler

This block captures a line of pixel codes for a column driver. Each rising clock edge can take in one word of three 6-bit channel codes. A full line is a fixed number of such words, 88 by default, and each word goes into its own column group of the sampling storage. A line begins only when a start enable is seen on the active enable input. The block then captures exactly one word per clock until the line is complete, and after that it waits in standby for the next start.

Several devices can be chained. Each device raises a one-cycle cascade enable on its outgoing pin one clock before its last capture. That pin can drive the incoming enable of the next device directly, so the next device takes over with no gap on the data bus. A static direction input decides three things: which of the two enable pins is the input, which one is the output, and whether groups fill from the lowest index upward or from the highest index downward. A polarity input can invert every bit of a word before it is stored. A one-cycle done pulse tells a downstream load stage that the line is complete.

Top module: `colgrp_sampler`

## Requirements
- R1: While `rst_n` is low at a rising edge, the block goes to standby. At the following edges `en_a_out`, `en_b_out` and `line_done` stay low until a new start is accepted. A transfer that was in progress is abandoned and produces no `line_done`.
- R2: A high on the active enable input is registered at one rising edge. The first word is captured at the next rising edge, not at the registering edge. It goes to group 0 when `dir_fwd`=1 and to group NUM_GROUPS-1 when `dir_fwd`=0.
- R3: A started line captures exactly NUM_GROUPS words on consecutive edges and then returns to standby. Enable highs seen while a line is in progress, including at the edge of the final capture, have no effect.
- R4: With `dir_fwd`=1, `en_a_in` is the start input and `en_b_out` carries the cascade enable, and word k goes to group k. With `dir_fwd`=0, `en_b_in` and `en_a_out` take those roles, and word k goes to group NUM_GROUPS-1-k. The output on the inactive side stays low, and the input on the inactive side is ignored.
- R5: The active cascade output is high for exactly one cycle. It is set by the rising edge that comes one edge before the final capture edge.
- R6: Each stored word equals `pix_in` XOR `pol_inv` replicated on every bit. `pol_inv` is sampled at the same edge as the data word.
- R7: Group g occupies `line_data[g*18 +: 18]`. Within a group, channel X is bits [5:0], Y is bits [11:6] and Z is bits [17:12]. Each field is weighted binary, with bit 5 worth 32 and bit 0 worth 1. `pix_in` uses the same field layout.
- R8: `line_done` is high for exactly one cycle, in the cycle that follows the final capture edge. It rises exactly one cycle after the cascade output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Transfer clock, rising edge active |
| rst_n | input | 1 | Synchronous active-low reset |
| dir_fwd | input | 1 | Static direction: 1 = fill upward with A as input, 0 = fill downward with B as input |
| en_a_in | input | 1 | Enable input on side A (used when `dir_fwd`=1) |
| en_b_in | input | 1 | Enable input on side B (used when `dir_fwd`=0) |
| en_a_out | output | 1 | Cascade enable out on side A (active when `dir_fwd`=0) |
| en_b_out | output | 1 | Cascade enable out on side B (active when `dir_fwd`=1) |
| pol_inv | input | 1 | Invert all bits of the captured word when high |
| pix_in | input | 18 | Three 6-bit channel codes: X [5:0], Y [11:6], Z [17:12] |
| line_data | output | 1584 | Sampling storage, 88 groups of 18 bits |
| line_done | output | 1 | One-cycle pulse after the last capture of a line |

## Verification
A counter that is off by one shows up in two places. The cascade pulse appears an edge early or late, and `line_done` is then no longer exactly one cycle after it. A downstream device would see the fault within the same line. A wrong group index or a wrong direction decode puts a word into the wrong slice of `line_data`. This is visible at the edge right after the faulty capture, because the bench compares every written group on every cycle. A busy flag that fails to block repeated enables restarts the count. That shows up as a missing or extra cascade pulse or done pulse and as overwritten early groups within the same line.

// File: rtl/pxs_pkg.sv
package pxs_pkg;
   localparam int unsigned DEF_GROUPS = 88;
   localparam int unsigned DEF_CHANS  = 3;
   localparam int unsigned DEF_CODE_W = 6;

   typedef enum logic {
      ST_IDLE = 1'b0,
      ST_RUN  = 1'b1
   } seq_state_e;
endpackage

// File: rtl/pxs_seq.sv
// Line sequencer: start acceptance, capture counter, cascade and done pulses.
module pxs_seq
   import pxs_pkg::*;
#(
   parameter int unsigned NUM_GROUPS = DEF_GROUPS,
   parameter int unsigned CNT_W      = $clog2(DEF_GROUPS)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start_req,
   output logic             cap_en,
   output logic [CNT_W-1:0] cap_cnt,
   output logic             casc,
   output logic             done
);
   localparam logic [CNT_W-1:0] LAST_IDX   = CNT_W'(NUM_GROUPS - 1);
   localparam logic [CNT_W-1:0] PENULT_IDX = CNT_W'(NUM_GROUPS - 2);

   seq_state_e       state_q;
   logic [CNT_W-1:0] cnt_q;
   logic             casc_q;
   logic             done_q;
   logic             run;

   assign run = (state_q == ST_RUN);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q <= ST_IDLE;
         cnt_q   <= '0;
         casc_q  <= 1'b0;
         done_q  <= 1'b0;
      end else begin
         casc_q <= run && (cnt_q == PENULT_IDX);
         done_q <= run && (cnt_q == LAST_IDX);
         if (!run) begin
            if (start_req) begin
               state_q <= ST_RUN;
               cnt_q   <= '0;
            end
         end else if (cnt_q == LAST_IDX) begin
            state_q <= ST_IDLE;
         end else begin
            cnt_q <= cnt_q + 1'b1;
         end
      end
   end

   assign cap_en  = run;
   assign cap_cnt = cnt_q;
   assign casc    = casc_q;
   assign done    = done_q;
endmodule

// File: rtl/pxs_route.sv
// Direction steering: enable pin roles and group index order.
module pxs_route #(
   parameter int unsigned NUM_GROUPS = 88,
   parameter int unsigned CNT_W      = 7
) (
   input  logic             dir_fwd,
   input  logic             en_a_in,
   input  logic             en_b_in,
   input  logic             casc,
   input  logic [CNT_W-1:0] cap_cnt,
   output logic             start_req,
   output logic             en_a_out,
   output logic             en_b_out,
   output logic [CNT_W-1:0] grp_idx
);
   localparam logic [CNT_W-1:0] TOP_IDX = CNT_W'(NUM_GROUPS - 1);

   assign start_req = dir_fwd ? en_a_in : en_b_in;
   assign en_b_out  = dir_fwd & casc;
   assign en_a_out  = ~dir_fwd & casc;
   assign grp_idx   = dir_fwd ? cap_cnt : (TOP_IDX - cap_cnt);
endmodule

// File: rtl/pxs_store.sv
// Sampling storage: one row per group, word inverted by polarity before the write.
module pxs_store #(
   parameter int unsigned NUM_GROUPS = 88,
   parameter int unsigned WORD_W     = 18,
   parameter int unsigned CNT_W      = 7
) (
   input  logic                         clk,
   input  logic                         wr_en,
   input  logic [CNT_W-1:0]             wr_idx,
   input  logic                         pol_inv,
   input  logic [WORD_W-1:0]            word_in,
   output logic [NUM_GROUPS*WORD_W-1:0] line_o
);
   logic [WORD_W-1:0] word_fix;

   assign word_fix = word_in ^ {WORD_W{pol_inv}};

   for (genvar g = 0; g < NUM_GROUPS; g++) begin : g_row
      logic [WORD_W-1:0] row_q;
      always_ff @(posedge clk) begin
         if (wr_en && (wr_idx == CNT_W'(g))) row_q <= word_fix;
      end
      assign line_o[g*WORD_W +: WORD_W] = row_q;
   end
endmodule

// File: rtl/colgrp_sampler.sv
module colgrp_sampler
   import pxs_pkg::*;
#(
   parameter int unsigned NUM_GROUPS = DEF_GROUPS,
   parameter int unsigned NUM_CHANS  = DEF_CHANS,
   parameter int unsigned CODE_W     = DEF_CODE_W,
   localparam int unsigned WORD_W    = NUM_CHANS * CODE_W,
   localparam int unsigned LINE_W    = NUM_GROUPS * WORD_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              dir_fwd,
   input  logic              en_a_in,
   input  logic              en_b_in,
   output logic              en_a_out,
   output logic              en_b_out,
   input  logic              pol_inv,
   input  logic [WORD_W-1:0] pix_in,
   output logic [LINE_W-1:0] line_data,
   output logic              line_done
);
   localparam int unsigned CNT_W = (NUM_GROUPS > 2) ? $clog2(NUM_GROUPS) : 1;

   if (NUM_GROUPS < 2) begin : g_bad_groups
      $error("colgrp_sampler: NUM_GROUPS must be at least 2");
   end
   if (NUM_CHANS < 1 || CODE_W < 1) begin : g_bad_word
      $error("colgrp_sampler: NUM_CHANS and CODE_W must be positive");
   end

   logic             start_req;
   logic             cap_en;
   logic [CNT_W-1:0] cap_cnt;
   logic [CNT_W-1:0] grp_idx;
   logic             casc;

   pxs_seq #(.NUM_GROUPS(NUM_GROUPS), .CNT_W(CNT_W)) seq_i (
      .clk      (clk),
      .rst_n    (rst_n),
      .start_req(start_req),
      .cap_en   (cap_en),
      .cap_cnt  (cap_cnt),
      .casc     (casc),
      .done     (line_done)
   );

   pxs_route #(.NUM_GROUPS(NUM_GROUPS), .CNT_W(CNT_W)) route_i (
      .dir_fwd  (dir_fwd),
      .en_a_in  (en_a_in),
      .en_b_in  (en_b_in),
      .casc     (casc),
      .cap_cnt  (cap_cnt),
      .start_req(start_req),
      .en_a_out (en_a_out),
      .en_b_out (en_b_out),
      .grp_idx  (grp_idx)
   );

   pxs_store #(.NUM_GROUPS(NUM_GROUPS), .WORD_W(WORD_W), .CNT_W(CNT_W)) store_i (
      .clk    (clk),
      .wr_en  (cap_en),
      .wr_idx (grp_idx),
      .pol_inv(pol_inv),
      .word_in(pix_in),
      .line_o (line_data)
   );
endmodule

// File: rtl/pxs_checker.sv
module pxs_checker (
   input logic clk,
   input logic rst_n,
   input logic dir_fwd,
   input logic en_a_out,
   input logic en_b_out,
   input logic line_done
);
   logic casc_any;
   assign casc_any = en_a_out | en_b_out;

   assert_casc_single_R5: assert property (@(posedge clk) disable iff (!rst_n)
      casc_any |=> !casc_any);

   assert_done_after_casc_R8: assert property (@(posedge clk) disable iff (!rst_n)
      casc_any |=> line_done);

   assert_done_single_R8: assert property (@(posedge clk) disable iff (!rst_n)
      line_done |=> !line_done);

   assert_side_a_quiet_R4: assert property (@(posedge clk) disable iff (!rst_n)
      dir_fwd |-> !en_a_out);

   assert_side_b_quiet_R4: assert property (@(posedge clk) disable iff (!rst_n)
      !dir_fwd |-> !en_b_out);
endmodule

bind colgrp_sampler pxs_checker chk_i (
   .clk      (clk),
   .rst_n    (rst_n),
   .dir_fwd  (dir_fwd),
   .en_a_out (en_a_out),
   .en_b_out (en_b_out),
   .line_done(line_done)
);

// File: tb/colgrp_sampler_tb_top.sv
module colgrp_sampler_tb_top;
   localparam int NG = 88;
   localparam int WW = 18;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          dir_fwd = 1'b1;
   logic          en_a_in = 1'b0;
   logic          en_b_in = 1'b0;
   logic          pol_inv = 1'b0;
   logic [WW-1:0] pix_in = '0;
   logic          en_a_out, en_b_out, line_done;
   logic [NG*WW-1:0] line_data;

   always #10 clk = ~clk;

   colgrp_sampler dut_i (
      .clk(clk), .rst_n(rst_n), .dir_fwd(dir_fwd),
      .en_a_in(en_a_in), .en_b_in(en_b_in),
      .en_a_out(en_a_out), .en_b_out(en_b_out),
      .pol_inv(pol_inv), .pix_in(pix_in),
      .line_data(line_data), .line_done(line_done)
   );

   int checks = 0;
   int fails  = 0;

   task automatic chk(input bit ok, input string req, input string what,
                      input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s %s act=%0h exp=%0h", req, what, act, exp);
      end
   endtask

   // behavioural reference
   bit            m_busy = 0;
   int            m_cnt  = 0;
   bit            m_casc = 0;
   bit            m_done = 0;
   logic [WW-1:0] m_mem [NG];
   bit            m_val [NG];
   int            cyc = 0, done_seen = 0, casc_seen = 0, casc_cyc = 0, done_cyc = 0;

   always @(posedge clk) begin
      bit nc, nd;
      cyc++;
      if (!rst_n) begin
         m_busy = 0; m_cnt = 0; m_casc = 0; m_done = 0;
         for (int g = 0; g < NG; g++) m_val[g] = 0;
      end else begin
         nc = m_busy && (m_cnt == NG - 2);
         nd = m_busy && (m_cnt == NG - 1);
         if (m_busy) begin
            int gi;
            gi = dir_fwd ? m_cnt : NG - 1 - m_cnt;
            m_mem[gi] = pix_in ^ {WW{pol_inv}};
            m_val[gi] = 1;
            if (m_cnt == NG - 1) m_busy = 0;
            else m_cnt++;
         end else if (dir_fwd ? en_a_in : en_b_in) begin
            m_busy = 1; m_cnt = 0;
         end
         m_casc = nc; m_done = nd;
      end
   end

   always @(negedge clk) begin
      int bad;
      bad = -1;
      chk(en_b_out === (dir_fwd && m_casc), "R5", "side B cascade", 64'(en_b_out), 64'(dir_fwd && m_casc));
      chk(en_a_out === (!dir_fwd && m_casc), "R4", "side A cascade", 64'(en_a_out), 64'(!dir_fwd && m_casc));
      chk(line_done === m_done, "R8", "line_done", 64'(line_done), 64'(m_done));
      for (int g = 0; g < NG; g++)
         if (m_val[g] && bad < 0 && line_data[g*WW +: WW] !== m_mem[g]) bad = g;
      if (bad >= 0) chk(1'b0, "R6", "group contents", 64'(line_data[bad*WW +: WW]), 64'(m_mem[bad]));
      else chk(1'b1, "R6", "group contents", 0, 0);
      if (en_a_out || en_b_out) begin casc_seen++; casc_cyc = cyc; end
      if (line_done) begin done_seen++; done_cyc = cyc; end
   end

   function automatic logic [WW-1:0] pat(int k);
      return WW'((k * 40503) ^ (k << 9) ^ 18'h15A5A);
   endfunction

   task automatic step();
      @(negedge clk); #2;
   endtask

   // polmode: 0 none, 1 all inverted, 2 alternate per word
   task automatic run_line(input bit dir, input int polmode, input int base, input bit noisy);
      step(); dir_fwd = dir;
      step();
      if (dir) en_a_in = 1; else en_b_in = 1;
      pix_in = pat(base + 500);
      for (int k = 0; k < NG; k++) begin
         step();
         pix_in  = pat(base + k);
         pol_inv = (polmode == 2) ? k[0] : (polmode == 1);
         if (dir) en_a_in = noisy && ((k % 9 == 4) || k == NG - 1);
         else     en_b_in = noisy && ((k % 9 == 4) || k == NG - 1);
      end
      step();
      en_a_in = 0; en_b_in = 0; pol_inv = 0; pix_in = '0;
      repeat (4) step();
   endtask

   initial begin
      int d0, c0;
      logic [WW-1:0] w;
      repeat (3) step();
      chk(en_a_out === 0 && en_b_out === 0 && line_done === 0, "R1", "outputs after reset",
          64'({en_a_out, en_b_out, line_done}), 0);
      rst_n = 1;
      repeat (3) step();

      // forward, no inversion, quiet enables
      d0 = done_seen; c0 = casc_seen;
      run_line(1'b1, 0, 0, 1'b0);
      chk(done_seen - d0 == 1, "R3", "done pulses per line", 64'(done_seen - d0), 1);
      chk(casc_seen - c0 == 1, "R5", "cascade pulses per line", 64'(casc_seen - c0), 1);
      chk(done_cyc - casc_cyc == 1, "R8", "done one cycle after cascade", 64'(done_cyc - casc_cyc), 1);
      chk(line_data[0 +: WW] === pat(0), "R2", "first word in group 0", 64'(line_data[0 +: WW]), 64'(pat(0)));
      chk(line_data[(NG-1)*WW +: WW] === pat(NG-1), "R3", "last word in top group",
          64'(line_data[(NG-1)*WW +: WW]), 64'(pat(NG-1)));
      w = pat(3);
      chk(line_data[3*WW +: 6] === w[5:0] && line_data[3*WW+12 +: 6] === w[17:12], "R7", "X and Z field position",
          64'(line_data[3*WW +: WW]), 64'(w));

      // reverse, all inverted, noisy enables (incl. on last capture edge)
      d0 = done_seen; c0 = casc_seen;
      run_line(1'b0, 1, 100, 1'b1);
      chk(done_seen - d0 == 1, "R3", "noisy enables ignored", 64'(done_seen - d0), 1);
      chk(casc_seen - c0 == 1, "R5", "reverse cascade pulses", 64'(casc_seen - c0), 1);
      chk(line_data[(NG-1)*WW +: WW] === ~pat(100), "R4", "reverse first word in top group",
          64'(line_data[(NG-1)*WW +: WW]), 64'(~pat(100)));
      chk(line_data[0 +: WW] === ~pat(100 + NG - 1), "R6", "inverted last word in group 0",
          64'(line_data[0 +: WW]), 64'(~pat(100 + NG - 1)));

      // forward, alternating polarity, noisy
      d0 = done_seen;
      run_line(1'b1, 2, 300, 1'b1);
      chk(line_data[5*WW +: WW] === ~pat(305), "R6", "odd word inverted", 64'(line_data[5*WW +: WW]), 64'(~pat(305)));
      chk(line_data[6*WW +: WW] === pat(306), "R6", "even word plain", 64'(line_data[6*WW +: WW]), 64'(pat(306)));
      chk(done_seen - d0 == 1, "R3", "alternating line done", 64'(done_seen - d0), 1);

      // wrong-side enable in each direction
      d0 = done_seen; c0 = casc_seen;
      step(); en_b_in = 1; step(); en_b_in = 0;
      repeat (NG + 10) step();
      dir_fwd = 0; step(); en_a_in = 1; step(); en_a_in = 0;
      repeat (NG + 10) step();
      chk(done_seen == d0 && casc_seen == c0, "R4", "inactive-side enable ignored",
          64'(done_seen - d0), 0);

      // reset in the middle of a line
      d0 = done_seen;
      dir_fwd = 1; step(); en_a_in = 1;
      for (int k = 0; k < 40; k++) begin step(); en_a_in = 0; pix_in = pat(700 + k); end
      rst_n = 0; step(); step();
      chk(en_a_out === 0 && en_b_out === 0 && line_done === 0, "R1", "outputs during mid-line reset",
          64'({en_a_out, en_b_out, line_done}), 0);
      rst_n = 1;
      repeat (NG + 10) step();
      chk(done_seen == d0, "R1", "abandoned line gives no done", 64'(done_seen - d0), 0);
      run_line(1'b1, 0, 900, 1'b0);
      chk(done_seen - d0 == 1, "R1", "fresh start after reset", 64'(done_seen - d0), 1);
      chk(line_data[0 +: WW] === pat(900), "R2", "restart fills group 0", 64'(line_data[0 +: WW]), 64'(pat(900)));

      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end

   initial begin
      #(20 * 20000);
      checks++; fails++;
      $display("FAIL R3 watchdog expired act=%0d exp=%0d", cyc, 0);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end
endmodule